// File: doc/BRIEF.md
# Autoranging Gain Select Controller

This block picks, once per sample, one of two attenuation settings for an analog path that feeds a 20 MHz ADC. The settings are divide by 1 and divide by 16. A comparator watches the signal level upstream of a fixed 100 ns analog delay, which is two sample periods. The block captures that comparator bit in a register and decides the gain. It then drives a pair of registered, mutually exclusive switch enables.

A large level selects divide by 16 at once. The path returns to divide by 1 only after the comparator has stayed low for a programmable number of consecutive samples, which keeps the switches from chattering. A processor-driven force mode can pin either setting and bypass the automatic decision.

Beside the switch enables, the block outputs a one-bit range tag. This is the switch state delayed by a parameterised number of sample clocks (two by default), so that each ADC word can be paired with the gain it passed through. Reset selects divide by 16 as the safe setting.

Top module: `range_sel_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sw_div16_o` is 1, `sw_div1_o` is 0 and `range_tag_o` is 1. Tag value 1 means divide by 16 and 0 means divide by 1.
- R2: Exactly one of `sw_div1_o` and `sw_div16_o` is 1 in every cycle.
- R3: In auto mode, a comparator high applied before clock edge k is captured at edge k. The captured high selects divide by 16 at edge k+1, so the switches settle within the two-sample window.
- R4: In auto mode, the switches move from divide by 16 to divide by 1 only after the captured comparator bit has been low for max(N,1) consecutive samples, where N is `holdoff_i`. With the low first applied before edge 1, `sw_div1_o` first reads 1 after edge max(N,1)+1.
- R5: A single captured high sample during a low run restarts the count. A low run shorter than N never reaches divide by 1.
- R6: When `force_en_i` is 1 at an edge, the switch state after that edge is divide by 16 if `force_atten_i` is 1 and divide by 1 if it is 0, whatever the comparator shows.
- R7: `range_tag_o` equals the value `sw_div16_o` had TAG_LAG cycles earlier (TAG_LAG = 2 by default).
- R8: The low-run count keeps advancing while force mode is active. If force is released with the count already satisfied and the comparator still low, divide by 1 is selected at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| level_hi_i | input | 1 | Comparator bit; 1 means the level needs divide by 16 |
| force_en_i | input | 1 | 1 bypasses the automatic decision |
| force_atten_i | input | 1 | Forced setting: 1 = divide by 16, 0 = divide by 1 |
| holdoff_i | input | CNT_W | Consecutive low samples required before dropping to divide by 1 |
| sw_div1_o | output | 1 | Switch enable for divide by 1 |
| sw_div16_o | output | 1 | Switch enable for divide by 16 |
| range_tag_o | output | 1 | Switch state delayed by TAG_LAG samples |

## Verification
The bench builds the block with CNT_W = 3 and TAG_LAG = 2. A 3-bit hold-off lets every value from 0 to 7 be swept, including the zero case and the saturated run counter. For each value the bench checks the exact edge at which divide by 1 appears, and it checks runs one sample short of the hold-off with a single-high interruption. A two-sample tag delay keeps the alignment check short enough to run on every sample, across all four force combinations and the release back to auto mode.

// File: rtl/range_sel_pkg.sv
package range_sel_pkg;

  typedef enum logic {
    ATT_DIV1  = 1'b0,
    ATT_DIV16 = 1'b1
  } atten_e;

  // True once the run seen so far, plus the current low sample, covers the need.
  // A need of zero behaves as a need of one.
  function automatic logic run_reaches(input int unsigned run_prev,
                                       input int unsigned need);
    return (run_prev + 1) >= need;
  endfunction

endpackage

// File: rtl/level_latch.sv
module level_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  // Resets high so the path is treated as large until a real sample arrives.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) q_o <= 1'b1;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/holdoff_counter.sv
module holdoff_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             low_i,
  input  logic [CNT_W-1:0] need_i,
  output logic [CNT_W-1:0] run_o,
  output logic             met_o
);
  import range_sel_pkg::*;

  localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)             run_q <= '0;
    else if (!low_i)         run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
  end

  assign run_o = run_q;
  assign met_o = low_i && run_reaches(32'(run_q), 32'(need_i));
endmodule

// File: rtl/tag_delay.sv
module tag_delay #(
  parameter int LAG = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (LAG == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_pipe
      logic [LAG-1:0] stage_q;
      for (genvar i = 0; i < LAG; i++) begin : g_stage
        always_ff @(posedge clk_i) begin
          if (!rst_ni) stage_q[i] <= 1'b1;
          else         stage_q[i] <= (i == 0) ? d_i : stage_q[(i == 0) ? 0 : i-1];
        end
      end
      assign q_o = stage_q[LAG-1];
    end
  endgenerate
endmodule

// File: rtl/range_sel_ctrl.sv
module range_sel_ctrl #(
  parameter int CNT_W   = 4,
  parameter int TAG_LAG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             level_hi_i,
  input  logic             force_en_i,
  input  logic             force_atten_i,
  input  logic [CNT_W-1:0] holdoff_i,
  output logic             sw_div1_o,
  output logic             sw_div16_o,
  output logic             range_tag_o
);
  import range_sel_pkg::*;

  logic             lvl_q;
  logic [CNT_W-1:0] run_cnt;
  logic             hold_met;
  atten_e           sel_q, sel_d;

  level_latch u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (level_hi_i),
    .q_o   (lvl_q)
  );

  holdoff_counter #(.CNT_W(CNT_W)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .low_i (!lvl_q),
    .need_i(holdoff_i),
    .run_o (run_cnt),
    .met_o (hold_met)
  );

  always_comb begin
    sel_d = sel_q;
    if (force_en_i)    sel_d = force_atten_i ? ATT_DIV16 : ATT_DIV1;
    else if (lvl_q)    sel_d = ATT_DIV16;
    else if (hold_met) sel_d = ATT_DIV1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sel_q <= ATT_DIV16;
    else         sel_q <= sel_d;
  end

  assign sw_div16_o = (sel_q == ATT_DIV16);
  assign sw_div1_o  = (sel_q == ATT_DIV1);

  tag_delay #(.LAG(TAG_LAG)) u_tag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sw_div16_o),
    .q_o   (range_tag_o)
  );
endmodule

// File: rtl/range_sel_chk.sv
module range_sel_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             force_en_i,
  input logic             force_atten_i,
  input logic             lvl_q,
  input logic             hold_met,
  input logic [CNT_W-1:0] run_cnt,
  input logic             sw_div1_o,
  input logic             sw_div16_o
);
  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_div1_o != sw_div16_o);

  a_r3_high_selects_div16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q && !force_en_i) |=> sw_div16_o);

  a_r6_force_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_en_i |=> (sw_div16_o == $past(force_atten_i)));

  a_r4_drop_needs_holdoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_en_i && !hold_met && sw_div16_o) |=> sw_div16_o);

  a_r5_high_clears_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q |=> (run_cnt == '0));
endmodule

bind range_sel_ctrl range_sel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .force_en_i   (force_en_i),
  .force_atten_i(force_atten_i),
  .lvl_q        (lvl_q),
  .hold_met     (hold_met),
  .run_cnt      (run_cnt),
  .sw_div1_o    (sw_div1_o),
  .sw_div16_o   (sw_div16_o)
);

// File: tb/range_sel_ctrl_bench.sv
module range_sel_ctrl_bench;
  localparam int CW  = 3;
  localparam int LAG = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          level = 1'b0;
  logic          f_en = 1'b0;
  logic          f_att = 1'b0;
  logic [CW-1:0] hold = '0;
  logic          div1, div16, tag;

  int checks = 0;
  int errors = 0;
  logic [LAG-1:0] hist;  // previously sampled div16 values, [0] newest

  always #5 clk = ~clk;

  range_sel_ctrl #(.CNT_W(CW), .TAG_LAG(LAG)) u_range_sel_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .level_hi_i(level), .force_en_i(f_en),
    .force_atten_i(f_att), .holdoff_i(hold), .sw_div1_o(div1),
    .sw_div16_o(div16), .range_tag_o(tag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One clock edge, then sample at the falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check("R2 onehot", div1 ^ div16, 1'b1);
    check("R7 tag alignment", tag, hist[LAG-1]);
    hist = {hist[LAG-2:0], div16};
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst_n = 1'b0; f_en = 1'b0; level = 1'b0; hold = CW'(n);
    repeat (3) @(negedge clk);
    check("R1 reset div16", div16, 1'b1);
    check("R1 reset div1", div1, 1'b0);
    check("R1 reset tag", tag, 1'b1);
    rst_n = 1'b1;
    hist = '1;
    step();
    check("R1 first cycle div16", div16, 1'b1);
  endtask

  initial begin
    for (int n = 0; n < (1 << CW); n++) begin
      int need;
      need = (n == 0) ? 1 : n;
      do_reset(n);
      level = 1'b1;
      repeat (3) step();
      level = 1'b0;
      for (int k = 1; k <= 10; k++) begin
        step();
        check("R4 holdoff timing", div1, (k >= need + 1) ? 1'b1 : 1'b0);
      end
      // back up to divide by 16: two edges of latency
      level = 1'b1;
      step();
      check("R3 one edge still div1", div1, 1'b1);
      step();
      check("R3 two edges div16", div16, 1'b1);
      step();
      if (n >= 2) begin
        for (int rep = 0; rep < 2; rep++) begin
          level = 1'b0;
          for (int k = 0; k < n - 1; k++) begin
            step();
            check("R5 short run stays div16", div16, 1'b1);
          end
          level = 1'b1;
          step();
          check("R5 interrupted run div16", div16, 1'b1);
        end
      end
      // force mode combinations
      for (int fa = 0; fa < 2; fa++) begin
        for (int lv = 0; lv < 2; lv++) begin
          f_en = 1'b1; f_att = fa[0]; level = lv[0];
          step();
          check("R6 force applies", div16, fa[0]);
          step();
          check("R6 force holds", div16, fa[0]);
        end
      end
      // count keeps running under force; release resumes auto at once
      f_en = 1'b1; f_att = 1'b1; level = 1'b0;
      repeat (10) step();
      check("R6 forced div16 under low level", div16, 1'b1);
      f_en = 1'b0;
      step();
      check("R8 release drops to div1", div1, 1'b1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule